// File: doc/BRIEF.md
# Compare-Action Waveform Timer Channel

This block is a single timer channel that generates waveforms. A counter advances on each cycle in which the `tick` input is high. The prescaler that produces `tick` sits outside the block.

Three compare registers, A, B and C, are checked against the counter on every counting tick. Other events can also change the outputs: a selectable external edge and a software trigger. For each such event, each of the two outputs, `tioa` and `tiob`, has its own 2-bit action: keep, set, clear or toggle.

The counter has four shapes, chosen by a mode field:
- up only
- up/down
- up with an automatic restart at compare C
- up/down with the top of the count at compare C

A compare-C match can also freeze the counter or switch its clock off. Software talks to the channel through a plain single-cycle register port. Reads are registered and arrive one cycle later. Sticky event flags drive an interrupt line through a mask.

Top module: `wave_timer_channel`

## Requirements
- R1: After a synchronous reset, the counter is 0, both outputs are low, the clock is off, all flags and mask bits are 0, and `irq` is low.
- R2: The word address map is: 0 control, 1 mode, 2/3/4 compare A/B/C, 5 counter (read), 6 status (read), 7 interrupt enable, 8 interrupt disable, 9 interrupt mask (read).
  - Mode word fields:
    - [1:0] shape
    - [2] stop on C
    - [3] clock off on C
    - [5:4] event edge
    - [7:6] event source
    - [8] event restarts counter
    - [17:16] A-on-compare-A
    - [19:18] A-on-C
    - [21:20] A-on-event
    - [23:22] A-on-software
    - [25:24] B-on-compare-B
    - [27:26] B-on-C
    - [29:28] B-on-event
    - [31:30] B-on-software
  - On a tick where the running counter equals compare A, B or C, that event fires and the counter then steps. In shape 0 (up) it steps by +1 and wraps.
- R3: Action codes are 0 keep, 1 set, 2 clear and 3 toggle. A control write with bit 2 set is a software trigger. It applies each output's software action in that same clock edge and resets the counter to 0, counting upward.
- R4: In shape 2, a tick at compare C loads 0 instead of C+1.
- R5: In shapes 1 and 3, counting rises to the top and then falls to 0 before rising again. The top is 0xFFFF in shape 1 and compare C in shape 3. The direction turns around at the top and at 0.
- R6: With the stop bit set, a compare-C tick holds the counter at C and leaves the clock on (status bit 16 = 1). A later trigger restarts counting from 0.
- R7: With the clock-off bit set, a compare-C tick holds the counter at C and clears status bit 16.
- R8: Control bit 0 turns the clock on and bit 1 turns it off; when both are written together, the clock goes off. With the clock off, ticks leave the counter unchanged.
- R9: The event source code selects the input: 0 `tiob_in`, 1/2/3 `xclk[0]`/`[1]`/`[2]`. The edge code selects which transitions count: 0 none, 1 rising, 2 falling, 3 both. An event applies its actions in the clock edge where it is seen. With mode bit 8 set, it also resets the counter to 0. Non-selected inputs and non-selected edges have no effect.
- R10: When several events hit one output in one clock, the first of these with a non-keep action decides: software, then event, then compare C, then compare A/B.
- R11: Status bit layout:
  - sticky flags: bit 0 overflow, bit 2 compare A, bit 3 compare B, bit 4 compare C, bit 7 external event
  - live bits: bit 16 clock on, bit 17 `tioa`, bit 18 `tiob`
  - Reading status returns the value before the read and clears the sticky flags.
- R12: Writing ones to the enable or disable register sets or clears mask bits at the flag positions. `irq` is high while any masked-in flag is set.
- R13: The overflow flag sets on an upward tick at 0xFFFF. In shape 0 the counter then wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| tick | input | 1 | Count enable from the prescaler |
| xclk | input | 3 | External event inputs |
| tiob_in | input | 1 | B-pin level used as event source 0 |
| tioa | output | 1 | Waveform output A |
| tiob | output | 1 | Waveform output B |
| irq | output | 1 | Interrupt request |

## Verification
The bench gives compare A and compare C the same value with opposite actions. A design that lets compare A win ends with `tioa` high instead of low. It also fires a software trigger and an external edge in the same clock with opposing actions, which exposes a reversed priority.

The up/down and auto-restart tests read the counter at the turn points. An off-by-one top would show up as an extra or missing step there.

A falling edge and a non-selected input are driven while the rising edge on input 0 is armed. An edge detector that ignores the selection would flip `tioa`.

A full 65536-tick run checks the wrap and the overflow interrupt. The run then confirms that a status read clears the flag and drops `irq`.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int DW = 32;
    localparam int AW = 4;

    typedef enum logic [1:0] {ACT_KEEP = 2'd0, ACT_SET = 2'd1, ACT_CLR = 2'd2, ACT_TGL = 2'd3} act_e;
    typedef enum logic [1:0] {WV_UP = 2'd0, WV_UPDN = 2'd1, WV_UP_RC = 2'd2, WV_UPDN_RC = 2'd3} wave_e;
    typedef enum logic [1:0] {EDG_OFF = 2'd0, EDG_RISE = 2'd1, EDG_FALL = 2'd2, EDG_ANY = 2'd3} edge_e;

    typedef struct packed {
        act_e       b_sw;
        act_e       b_ev;
        act_e       b_c;
        act_e       b_cmp;
        act_e       a_sw;
        act_e       a_ev;
        act_e       a_c;
        act_e       a_cmp;
        logic [6:0] spare;
        logic       ev_trig;
        logic [1:0] ev_src;
        edge_e      ev_edge;
        logic       c_off;
        logic       c_stop;
        wave_e      wave;
    } mode_t;

    localparam logic [AW-1:0] RG_CTRL  = 4'd0;
    localparam logic [AW-1:0] RG_MODE  = 4'd1;
    localparam logic [AW-1:0] RG_CMPA  = 4'd2;
    localparam logic [AW-1:0] RG_CMPB  = 4'd3;
    localparam logic [AW-1:0] RG_CMPC  = 4'd4;
    localparam logic [AW-1:0] RG_COUNT = 4'd5;
    localparam logic [AW-1:0] RG_STAT  = 4'd6;
    localparam logic [AW-1:0] RG_IEN   = 4'd7;
    localparam logic [AW-1:0] RG_IDIS  = 4'd8;
    localparam logic [AW-1:0] RG_IMASK = 4'd9;

    localparam int FL_OVF = 0;
    localparam int FL_HA  = 2;
    localparam int FL_HB  = 3;
    localparam int FL_HC  = 4;
    localparam int FL_EXT = 7;
    localparam logic [7:0] FL_VALID = 8'h9D;

    function automatic logic apply_act(act_e a, logic cur);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction
endpackage

// File: rtl/tc_evt_edge.sv
module tc_evt_edge
    import tc_pkg::*;
#(
    parameter int NSRC = 4,
    localparam int SW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_vec,
    input  logic [SW-1:0]   sel,
    input  edge_e           edg,
    output logic            evt
);
    logic cur, prev_q;

    assign cur = src_vec[sel];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cur;
    end

    always_comb begin
        case (edg)
            EDG_RISE: evt = cur & ~prev_q;
            EDG_FALL: evt = ~cur & prev_q;
            EDG_ANY:  evt = cur ^ prev_q;
            default:  evt = 1'b0;
        endcase
    end

    AST_NO_EVT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (edg == EDG_OFF) |-> !evt);  // R9
endmodule

// File: rtl/tc_out_act.sv
module tc_out_act
    import tc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev_sw,
    input  logic ev_ext,
    input  logic ev_c,
    input  logic ev_cmp,
    input  act_e act_sw,
    input  act_e act_ext,
    input  act_e act_c,
    input  act_e act_cmp,
    output logic lvl
);
    act_e pick;

    always_comb begin
        pick = ACT_KEEP;
        if (ev_cmp && act_cmp != ACT_KEEP) pick = act_cmp;
        if (ev_c   && act_c   != ACT_KEEP) pick = act_c;
        if (ev_ext && act_ext != ACT_KEEP) pick = act_ext;
        if (ev_sw  && act_sw  != ACT_KEEP) pick = act_sw;
    end

    always_ff @(posedge clk) begin
        if (rst) lvl <= 1'b0;
        else     lvl <= apply_act(pick, lvl);
    end

    AST_SW_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (ev_sw && act_sw == ACT_TGL) |=> (lvl != $past(lvl)));  // R3
    AST_SW_SET: assert property (@(posedge clk) disable iff (rst)
        (ev_sw && act_sw == ACT_SET) |=> lvl);  // R10
endmodule

// File: rtl/tc_count.sv
module tc_count
    import tc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en_req,
    input  logic          dis_req,
    input  logic          trig,
    input  wave_e         wave,
    input  logic          c_stop,
    input  logic          c_off,
    input  logic [CW-1:0] ra,
    input  logic [CW-1:0] rb,
    input  logic [CW-1:0] rc,
    output logic [CW-1:0] cv,
    output logic          en_q,
    output logic          hit_a,
    output logic          hit_b,
    output logic          hit_c,
    output logic          ovf
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic          stop_q, up_q, active, halt, nxt_up;
    logic [CW-1:0] top, nxt_cv;

    assign active = en_q & ~stop_q & tick;
    assign hit_a  = active && (cv == ra);
    assign hit_b  = active && (cv == rb);
    assign hit_c  = active && (cv == rc);
    assign ovf    = active && up_q && (cv == MAXV);
    assign halt   = hit_c & (c_stop | c_off);
    assign top    = (wave == WV_UPDN_RC) ? rc : MAXV;

    always_comb begin
        nxt_cv = cv + 1'b1;
        nxt_up = up_q;
        case (wave)
            WV_UP_RC: if (hit_c) nxt_cv = '0;
            WV_UPDN, WV_UPDN_RC: begin
                if (up_q) begin
                    if (cv == top) begin
                        nxt_up = 1'b0;
                        nxt_cv = cv - 1'b1;
                    end
                end else if (cv == '0) begin
                    nxt_up = 1'b1;
                end else begin
                    nxt_cv = cv - 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cv     <= '0;
            en_q   <= 1'b0;
            stop_q <= 1'b0;
            up_q   <= 1'b1;
        end else begin
            if (dis_req || (halt && c_off && !trig)) en_q <= 1'b0;
            else if (en_req)                         en_q <= 1'b1;
            if (trig) begin
                cv     <= '0;
                up_q   <= 1'b1;
                stop_q <= 1'b0;
            end else begin
                if (en_req) stop_q <= 1'b0;
                if (active) begin
                    if (halt) begin
                        if (c_stop) stop_q <= 1'b1;
                    end else begin
                        cv   <= nxt_cv;
                        up_q <= nxt_up;
                    end
                end
            end
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !trig) |=> (cv == $past(cv)));  // R8
    AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (rst)
        trig |=> (cv == '0));  // R6
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (halt && !trig) |=> (cv == $past(cv)));  // R7
    AST_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
        (en_req && dis_req) |=> !en_q);  // R8
endmodule

// File: rtl/wave_timer_channel.sv
module wave_timer_channel
    import tc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          tick,
    input  logic [2:0]    xclk,
    input  logic          tiob_in,
    output logic          tioa,
    output logic          tiob,
    output logic          irq
);
    localparam int NOUT = 2;

    mode_t         mode_q;
    logic [CW-1:0] ra_q, rb_q, rc_q, cv;
    logic [7:0]    flags_q, mask_q, set_vec;
    logic          en_q, hit_a, hit_b, hit_c, ovf, evt;
    logic          wr_ctrl, sw_trig, trig, rd_stat;
    logic          lvl_v [NOUT];
    logic          cmp_v [NOUT];
    act_e          asw_v [NOUT], aev_v [NOUT], ac_v [NOUT], acmp_v [NOUT];

    assign wr_ctrl = wr_en && (addr == RG_CTRL);
    assign sw_trig = wr_ctrl && wdata[2];
    assign trig    = sw_trig | (evt & mode_q.ev_trig);
    assign rd_stat = rd_en && (addr == RG_STAT);

    tc_evt_edge #(.NSRC(4)) u_evt (
        .clk(clk), .rst(rst), .src_vec({xclk, tiob_in}),
        .sel(mode_q.ev_src), .edg(mode_q.ev_edge), .evt(evt)
    );

    tc_count #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick),
        .en_req(wr_ctrl && wdata[0]), .dis_req(wr_ctrl && wdata[1]),
        .trig(trig), .wave(mode_q.wave), .c_stop(mode_q.c_stop), .c_off(mode_q.c_off),
        .ra(ra_q), .rb(rb_q), .rc(rc_q), .cv(cv), .en_q(en_q),
        .hit_a(hit_a), .hit_b(hit_b), .hit_c(hit_c), .ovf(ovf)
    );

    assign cmp_v[0]  = hit_a;
    assign cmp_v[1]  = hit_b;
    assign asw_v[0]  = mode_q.a_sw;
    assign asw_v[1]  = mode_q.b_sw;
    assign aev_v[0]  = mode_q.a_ev;
    assign aev_v[1]  = mode_q.b_ev;
    assign ac_v[0]   = mode_q.a_c;
    assign ac_v[1]   = mode_q.b_c;
    assign acmp_v[0] = mode_q.a_cmp;
    assign acmp_v[1] = mode_q.b_cmp;

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        tc_out_act u_act (
            .clk(clk), .rst(rst),
            .ev_sw(sw_trig), .ev_ext(evt), .ev_c(hit_c), .ev_cmp(cmp_v[i]),
            .act_sw(asw_v[i]), .act_ext(aev_v[i]), .act_c(ac_v[i]), .act_cmp(acmp_v[i]),
            .lvl(lvl_v[i])
        );
    end

    assign tioa = lvl_v[0];
    assign tiob = lvl_v[1];

    always_comb begin
        set_vec         = '0;
        set_vec[FL_OVF] = ovf;
        set_vec[FL_HA]  = hit_a;
        set_vec[FL_HB]  = hit_b;
        set_vec[FL_HC]  = hit_c;
        set_vec[FL_EXT] = evt;
    end

    assign irq = |(flags_q & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            ra_q    <= '0;
            rb_q    <= '0;
            rc_q    <= '0;
            flags_q <= '0;
            mask_q  <= '0;
            rdata   <= '0;
        end else begin
            flags_q <= (rd_stat ? 8'h00 : flags_q) | set_vec;
            if (wr_en) begin
                case (addr)
                    RG_MODE: mode_q <= mode_t'(wdata);
                    RG_CMPA: ra_q   <= wdata[CW-1:0];
                    RG_CMPB: rb_q   <= wdata[CW-1:0];
                    RG_CMPC: rc_q   <= wdata[CW-1:0];
                    RG_IEN:  mask_q <= mask_q | (wdata[7:0] & FL_VALID);
                    RG_IDIS: mask_q <= mask_q & ~wdata[7:0];
                    default: ;
                endcase
            end
            if (rd_en) begin
                case (addr)
                    RG_MODE:  rdata <= mode_q;
                    RG_CMPA:  rdata <= DW'(ra_q);
                    RG_CMPB:  rdata <= DW'(rb_q);
                    RG_CMPC:  rdata <= DW'(rc_q);
                    RG_COUNT: rdata <= DW'(cv);
                    RG_STAT:  rdata <= {13'd0, tiob, tioa, en_q, 8'd0, flags_q};
                    RG_IMASK: rdata <= {24'd0, mask_q};
                    default:  rdata <= '0;
                endcase
            end
        end
    end

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && set_vec == 8'h00) |=> (flags_q == 8'h00));  // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));  // R11
    AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (mask_q & ~FL_VALID) == 8'h00);  // R12
endmodule

// File: tb/tb_wave_timer_channel.sv
module tb_wave_timer_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, tiob_in = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  xclk = '0;
    logic [31:0] rdata;
    logic        tioa, tiob, irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    wave_timer_channel dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .xclk(xclk),
        .tiob_in(tiob_in), .tioa(tioa), .tiob(tiob), .irq(irq)
    );

    localparam logic [3:0] A_CTRL = 0, A_MODE = 1, A_RA = 2, A_RB = 3, A_RC = 4,
                           A_CV = 5, A_ST = 6, A_IEN = 7, A_IDIS = 8, A_IMSK = 9;

    // mode word, expected tioa, expected tiob after a software trigger (R3)
    localparam logic [33:0] VEC [5] = '{
        {32'h8040_0000, 1'b1, 1'b0},
        {32'hC0C0_0000, 1'b0, 1'b1},
        {32'h4000_0000, 1'b0, 1'b1},
        {32'h00C0_0000, 1'b1, 1'b1},
        {32'hC080_0000, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 outputs", {29'd0, tioa, tiob, irq}, 32'd0);
        rd(A_ST, v); chk("R1 status", v, 32'd0);
        rd(A_CV, v); chk("R1 counter", v, 32'd0);

        // R3 action codes from the vector table
        for (int i = 0; i < 5; i++) begin
            wr(A_MODE, VEC[i][33:2]);
            wr(A_CTRL, 32'h4);
            chk("R3 tioa", {31'd0, tioa}, {31'd0, VEC[i][1]});
            chk("R3 tiob", {31'd0, tiob}, {31'd0, VEC[i][0]});
        end

        // R8 clock off: ticks do nothing
        ticks(3); rd(A_CV, v); chk("R8 held", v, 32'd0);

        // R2 compare actions, shape up
        wr(A_MODE, 32'h0309_0000);
        wr(A_RA, 2); wr(A_RB, 3); wr(A_RC, 5);
        wr(A_CTRL, 32'h1); wr(A_CTRL, 32'h4);
        rd(A_ST, v);
        ticks(3); chk("R2 A set", {30'd0, tioa, tiob}, 32'b10);
        ticks(1); chk("R2 B toggle", {30'd0, tioa, tiob}, 32'b11);
        ticks(2); chk("R2 C clear", {30'd0, tioa, tiob}, 32'b01);
        rd(A_CV, v); chk("R2 count", v, 32'd6);
        rd(A_ST, v); chk("R11 flags", v, 32'h0005_001C);
        rd(A_ST, v); chk("R11 cleared", v, 32'h0005_0000);

        // R4 auto restart at C
        wr(A_MODE, 32'h2); wr(A_RC, 4); wr(A_CTRL, 32'h4);
        ticks(5); rd(A_CV, v); chk("R4 wrap", v, 32'd0);
        ticks(1); rd(A_CV, v); chk("R4 next", v, 32'd1);

        // R5 up/down with top at C
        wr(A_MODE, 32'h3); wr(A_RC, 3); wr(A_CTRL, 32'h4);
        ticks(4); rd(A_CV, v); chk("R5 falling", v, 32'd2);
        ticks(2); rd(A_CV, v); chk("R5 bottom", v, 32'd0);
        ticks(1); rd(A_CV, v); chk("R5 rising", v, 32'd1);

        // R6 stop on C
        wr(A_MODE, 32'h4); wr(A_RC, 2); wr(A_CTRL, 32'h4);
        ticks(5); rd(A_CV, v); chk("R6 hold", v, 32'd2);
        rd(A_ST, v); chk("R6 clock on", {31'd0, v[16]}, 32'd1);
        wr(A_CTRL, 32'h4); ticks(1); rd(A_CV, v); chk("R6 restart", v, 32'd1);

        // R7 clock off on C
        wr(A_MODE, 32'h8); wr(A_CTRL, 32'h4);
        ticks(5); rd(A_CV, v); chk("R7 hold", v, 32'd2);
        rd(A_ST, v); chk("R7 clock off", {31'd0, v[16]}, 32'd0);

        // R8 both enable and disable
        wr(A_CTRL, 32'h1); rd(A_ST, v); chk("R8 on", {31'd0, v[16]}, 32'd1);
        wr(A_CTRL, 32'h3); rd(A_ST, v); chk("R8 both off", {31'd0, v[16]}, 32'd0);

        // R9 external event: xclk0 rising, restart, toggle A
        wr(A_MODE, 32'h0030_0150); wr(A_RC, 100);
        wr(A_CTRL, 32'h1); wr(A_CTRL, 32'h4);
        ticks(3);
        @(negedge clk); xclk[0] = 1'b1;
        @(negedge clk); chk("R9 toggle", {31'd0, tioa}, 32'd1);
        rd(A_CV, v); chk("R9 restart", v, 32'd0);
        rd(A_ST, v); chk("R9 flag", {31'd0, v[7]}, 32'd1);
        @(negedge clk); xclk[0] = 1'b0;
        @(negedge clk); chk("R9 falling ignored", {31'd0, tioa}, 32'd1);
        xclk[1] = 1'b1;
        @(negedge clk); chk("R9 other input ignored", {31'd0, tioa}, 32'd1);
        xclk[1] = 1'b0;

        // R10 software beats event
        wr(A_MODE, 32'h0060_0150);
        @(negedge clk); xclk[0] = 1'b1;
        @(negedge clk); xclk[0] = 1'b0;
        chk("R10 event clear", {31'd0, tioa}, 32'd0);
        @(negedge clk); xclk[0] = 1'b1; wr_en = 1'b1; addr = A_CTRL; wdata = 32'h4;
        @(negedge clk); wr_en = 1'b0; xclk[0] = 1'b0;
        chk("R10 sw over event", {31'd0, tioa}, 32'd1);
        // R10 compare C beats compare A
        wr(A_MODE, 32'h0009_0000); wr(A_RA, 2); wr(A_RC, 2); wr(A_CTRL, 32'h4);
        ticks(3); chk("R10 C over A", {31'd0, tioa}, 32'd0);

        // R12 / R13 overflow interrupt
        wr(A_MODE, 32'h0); rd(A_ST, v);
        wr(A_IEN, 32'h3); rd(A_IMSK, v); chk("R12 mask", v, 32'h1);
        wr(A_CTRL, 32'h4);
        chk("R12 idle", {31'd0, irq}, 32'd0);
        ticks(65536);
        chk("R12 irq", {31'd0, irq}, 32'd1);
        rd(A_CV, v); chk("R13 wrap", v, 32'd0);
        rd(A_ST, v); chk("R13 flag", {31'd0, v[0]}, 32'd1);
        chk("R11 irq drops", {31'd0, irq}, 32'd0);
        wr(A_IDIS, 32'h1); rd(A_IMSK, v); chk("R12 disable", v, 32'h0);

        finish_run();
    end
endmodule